// File: doc/BRIEF.md
# Tagged Shared Byte Buffer

A circular byte buffer that several DMA channels share as one data store. Each stored byte keeps the identifier (tag) of the channel that wrote it. A writer asks for room for a burst of N bytes under one tag. The burst is taken whole or refused whole. A reader asks for N bytes under a tag, and the read is refused when too few bytes are stored or when the oldest byte belongs to another channel. The buffer also shows the tag of its oldest byte and answers whether any stored byte carries a queried tag. On a single-cycle command it removes every byte of one tag, packing the survivors together in their original order.

Every operation is a command handshake (valid/ready) followed by a byte stream. A push command that is taken opens a write stream of exactly N beats. A pop command that is taken opens a read stream of exactly N beats. Each beat moves on a cycle where both valid and ready are high, and either side may hold back for any number of cycles. While it holds back, the read side keeps its data stable. One operation runs at a time. Command ready stays low while a stream or a purge is in progress. A purge walks the occupied entries one per cycle with a busy flag raised.

Top module: `tagged_byte_fifo`

## Requirements
- R1: After synchronous reset, `level` is 0, `head_tag` is 0xFF, `has_tag` is 0, `purge_busy` is 0 and `push_req_ready` is 1.
- R2: A push command of N bytes (1 ≤ N ≤ MAX_BURST) is accepted when at least N entries are free. Its N beats are appended after the current tail, each stored with the command's tag, and `level` rises by one per beat.
- R3: A push command with fewer than N free entries finishes with status STALL. It writes nothing, `level` is unchanged, and the bytes already stored are read back intact later.
- R4: A pop command of N bytes with fewer than N bytes stored finishes with status STALL and moves no byte.
- R5: A pop command whose tag differs from the tag of the oldest byte (with at least N bytes stored) finishes with status ERROR. The head does not move, so a later pop with the right tag returns the same first byte.
- R6: An accepted pop streams N bytes oldest-first, with `rd_data` held stable while `rd_ready` is low. The head advances by one per beat and wraps modulo DEPTH.
- R7: `head_tag` is 0xFF when the buffer is empty, and otherwise equals the tag of the oldest stored byte.
- R8: `has_tag` is 1 exactly when some stored byte carries `query_tag`.
- R9: A `purge_start` pulse taken while idle removes every byte of `purge_tag`. The survivors keep their order, and `level` drops by the number removed. `purge_busy` is high for level+1 cycles, and both command readies are low during that time.
- R10: Command priority while idle is purge > pop > push: `pop_req_ready` is low while `purge_start` is high, and `push_req_ready` is low while `purge_start` or `pop_req_valid` is high. A push or pop length of 0 or above MAX_BURST finishes with status ERROR and does nothing else.
- R11: `op_done` pulses for one cycle after the edge that finishes an operation, which is the last stream beat, the refusal, or the end of a purge. `op_status` then reads 0 = OK, 1 = STALL, 2 = ERROR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_req_valid | input | 1 | Push command valid |
| push_req_ready | output | 1 | Push command can be taken |
| push_len | input | LEN_W | Burst length N of the push |
| push_tag | input | TAG_W | Tag for all bytes of the push |
| wr_valid | input | 1 | Write stream beat valid |
| wr_ready | output | 1 | Write stream open |
| wr_data | input | DATA_W | Write stream byte |
| pop_req_valid | input | 1 | Pop command valid |
| pop_req_ready | output | 1 | Pop command can be taken |
| pop_len | input | LEN_W | Burst length N of the pop |
| pop_tag | input | TAG_W | Tag the pop expects at the head |
| rd_valid | output | 1 | Read stream beat valid |
| rd_ready | input | 1 | Reader takes the beat |
| rd_data | output | DATA_W | Oldest stored byte |
| purge_start | input | 1 | Purge command pulse |
| purge_tag | input | TAG_W | Tag to remove |
| purge_busy | output | 1 | Purge walk in progress |
| op_done | output | 1 | Operation finished (one cycle) |
| op_status | output | 2 | 0 OK, 1 STALL, 2 ERROR |
| level | output | ADDR_W+1 | Number of stored bytes |
| head_tag | output | TAG_W | Tag of oldest byte, 0xFF if empty |
| query_tag | input | TAG_W | Tag for the presence query |
| has_tag | output | 1 | Some stored byte carries query_tag |

## Verification
The bench fills the buffer to exactly one entry short of full and then sends a two-byte push. A design that compared the length against the count, or that wrote part of the burst, would either take the push or corrupt the bytes that are later read back. A pop with the wrong tag is followed by a pop with the right tag that must return the very first byte; a design that advanced the head on the error would return a later byte. A purge runs on a full buffer whose live region has wrapped past the end of storage. A compaction that started at index zero, or that dropped order, would show up in the pops that follow. Length bounds, command priority and the one-cycle shape of the done pulse are checked directly at the ports.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PUSH  = 2'd1,
    S_POP   = 2'd2,
    S_PURGE = 2'd3
  } tbf_state_t;

  typedef enum logic [1:0] {
    RESP_OK    = 2'd0,
    RESP_STALL = 2'd1,
    RESP_ERR   = 2'd2
  } tbf_resp_t;
endpackage

// File: rtl/tbf_store.sv
module tbf_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               waddr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [TAG_W-1:0]                wtag,
  input  logic [ADDR_W-1:0]               head_addr,
  output logic [DATA_W-1:0]               head_data,
  output logic [TAG_W-1:0]                head_tag_raw,
  input  logic [ADDR_W-1:0]               scan_addr,
  output logic [DATA_W-1:0]               scan_data,
  output logic [TAG_W-1:0]                scan_tag,
  output logic [DEPTH-1:0][TAG_W-1:0]     tags_all
);
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      data_mem[waddr] <= wdata;
      tag_mem[waddr]  <= wtag;
    end
  end

  always_comb begin
    head_data    = data_mem[head_addr];
    head_tag_raw = tag_mem[head_addr];
    scan_data    = data_mem[scan_addr];
    scan_tag     = tag_mem[scan_addr];
    for (int k = 0; k < DEPTH; k++) tags_all[k] = tag_mem[k];
  end
endmodule

// File: rtl/tbf_scan.sv
module tbf_scan #(
  parameter int DEPTH = 256,
  parameter int TAG_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags_all,
  input  logic [ADDR_W-1:0]           head,
  input  logic [CNT_W-1:0]            count,
  input  logic [TAG_W-1:0]            query,
  output logic                        hit
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [ADDR_W-1:0] offs;
    assign offs        = ADDR_W'(k) - head;
    assign slot_hit[k] = ({1'b0, offs} < count) && (tags_all[k] == query);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/tbf_ctrl.sv
module tbf_ctrl
  import tbf_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int DATA_W    = 8,
  parameter int TAG_W     = 8,
  parameter int MAX_BURST = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int LEN_W  = $clog2(MAX_BURST + 1),
  localparam int CMP_W  = (CNT_W > LEN_W) ? CNT_W : LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req_valid,
  output logic              push_req_ready,
  input  logic [LEN_W-1:0]  push_len,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req_valid,
  output logic              pop_req_ready,
  input  logic [LEN_W-1:0]  pop_len,
  input  logic [TAG_W-1:0]  pop_tag,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              purge_start,
  input  logic [TAG_W-1:0]  purge_tag,
  output logic              purge_busy,
  output logic              op_done,
  output tbf_resp_t         op_status,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] head,
  input  logic [TAG_W-1:0]  head_tag_raw,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [TAG_W-1:0]  wtag,
  output logic [ADDR_W-1:0] scan_idx,
  input  logic [DATA_W-1:0] scan_data,
  input  logic [TAG_W-1:0]  scan_tag
);
  tbf_state_t        state;
  logic [LEN_W-1:0]  remaining;
  logic [TAG_W-1:0]  cur_tag;
  logic [ADDR_W-1:0] keep_idx;
  logic [CNT_W-1:0]  scan_left;
  logic [CNT_W-1:0]  kept;

  logic idle, push_fire, pop_fire;
  logic push_len_bad, pop_len_bad, push_stall, pop_stall, pop_tag_bad;
  logic scan_keep;
  logic [CMP_W-1:0] free_c, count_c, plen_c, qlen_c;
  logic [ADDR_W-1:0] tail;

  always_comb begin
    idle           = (state == S_IDLE);
    pop_req_ready  = idle && !purge_start;
    push_req_ready = idle && !purge_start && !pop_req_valid;
    pop_fire       = pop_req_valid && pop_req_ready;
    push_fire      = push_req_valid && push_req_ready;
    wr_ready       = (state == S_PUSH);
    rd_valid       = (state == S_POP);
    purge_busy     = (state == S_PURGE);

    free_c  = CMP_W'(CNT_W'(DEPTH) - count);
    count_c = CMP_W'(count);
    plen_c  = CMP_W'(push_len);
    qlen_c  = CMP_W'(pop_len);

    push_len_bad = (push_len == '0) || (push_len > LEN_W'(MAX_BURST));
    pop_len_bad  = (pop_len == '0) || (pop_len > LEN_W'(MAX_BURST));
    push_stall   = free_c < plen_c;
    pop_stall    = count_c < qlen_c;
    pop_tag_bad  = head_tag_raw != pop_tag;

    tail      = head + count[ADDR_W-1:0];
    scan_keep = (scan_tag != cur_tag);

    we    = 1'b0;
    waddr = tail;
    wdata = wr_data;
    wtag  = cur_tag;
    if (state == S_PUSH && wr_valid) begin
      we = 1'b1;
    end else if (state == S_PURGE && scan_left != '0 && scan_keep) begin
      we    = 1'b1;
      waddr = keep_idx;
      wdata = scan_data;
      wtag  = scan_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      count     <= '0;
      head      <= '0;
      remaining <= '0;
      cur_tag   <= '0;
      scan_idx  <= '0;
      keep_idx  <= '0;
      scan_left <= '0;
      kept      <= '0;
      op_done   <= 1'b0;
      op_status <= RESP_OK;
    end else begin
      op_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (purge_start) begin
            state     <= S_PURGE;
            cur_tag   <= purge_tag;
            scan_idx  <= head;
            keep_idx  <= head;
            scan_left <= count;
            kept      <= '0;
          end else if (pop_fire) begin
            if (pop_len_bad || pop_stall || pop_tag_bad) begin
              op_done   <= 1'b1;
              op_status <= pop_len_bad ? RESP_ERR : (pop_stall ? RESP_STALL : RESP_ERR);
            end else begin
              state     <= S_POP;
              remaining <= pop_len;
            end
          end else if (push_fire) begin
            if (push_len_bad || push_stall) begin
              op_done   <= 1'b1;
              op_status <= push_len_bad ? RESP_ERR : RESP_STALL;
            end else begin
              state     <= S_PUSH;
              remaining <= push_len;
              cur_tag   <= push_tag;
            end
          end
        end
        S_PUSH: begin
          if (wr_valid) begin
            count     <= count + CNT_W'(1);
            remaining <= remaining - LEN_W'(1);
            if (remaining == LEN_W'(1)) begin
              state     <= S_IDLE;
              op_done   <= 1'b1;
              op_status <= RESP_OK;
            end
          end
        end
        S_POP: begin
          if (rd_ready) begin
            head      <= head + ADDR_W'(1);
            count     <= count - CNT_W'(1);
            remaining <= remaining - LEN_W'(1);
            if (remaining == LEN_W'(1)) begin
              state     <= S_IDLE;
              op_done   <= 1'b1;
              op_status <= RESP_OK;
            end
          end
        end
        default: begin
          if (scan_left == '0) begin
            count     <= kept;
            state     <= S_IDLE;
            op_done   <= 1'b1;
            op_status <= RESP_OK;
          end else begin
            scan_idx  <= scan_idx + ADDR_W'(1);
            scan_left <= scan_left - CNT_W'(1);
            if (scan_keep) begin
              keep_idx <= keep_idx + ADDR_W'(1);
              kept     <= kept + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_refused_push_R3: assert property (@(posedge clk) disable iff (rst)
    (push_fire && !push_len_bad && push_stall) |=> (count == $past(count)) && (state == S_IDLE));

  assert_pop_error_head_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && !pop_len_bad && !pop_stall && pop_tag_bad) |=> (head == $past(head)) && (count == $past(count)));

  assert_pop_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> (head == $past(head) + ADDR_W'(1)));

  assert_purge_shrinks_R9: assert property (@(posedge clk) disable iff (rst)
    purge_busy |=> (count <= $past(count)));
endmodule

// File: rtl/tagged_byte_fifo.sv
module tagged_byte_fifo
  import tbf_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int DATA_W    = 8,
  parameter int TAG_W     = 8,
  parameter int MAX_BURST = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int LEN_W  = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req_valid,
  output logic              push_req_ready,
  input  logic [LEN_W-1:0]  push_len,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req_valid,
  output logic              pop_req_ready,
  input  logic [LEN_W-1:0]  pop_len,
  input  logic [TAG_W-1:0]  pop_tag,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              purge_start,
  input  logic [TAG_W-1:0]  purge_tag,
  output logic              purge_busy,
  output logic              op_done,
  output logic [1:0]        op_status,
  output logic [CNT_W-1:0]  level,
  output logic [TAG_W-1:0]  head_tag,
  input  logic [TAG_W-1:0]  query_tag,
  output logic              has_tag
);
  localparam logic [TAG_W-1:0] NO_TAG = '1;

  logic [ADDR_W-1:0]          head, waddr, scan_idx;
  logic                       we;
  logic [DATA_W-1:0]          wdata, scan_data;
  logic [TAG_W-1:0]           wtag, scan_tag, head_tag_raw;
  logic [DEPTH-1:0][TAG_W-1:0] tags_all;
  tbf_resp_t                  status_q;

  tbf_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .MAX_BURST(MAX_BURST)) u_ctrl (
    .clk, .rst,
    .push_req_valid, .push_req_ready, .push_len, .push_tag,
    .wr_valid, .wr_ready, .wr_data,
    .pop_req_valid, .pop_req_ready, .pop_len, .pop_tag,
    .rd_valid, .rd_ready,
    .purge_start, .purge_tag, .purge_busy,
    .op_done, .op_status(status_q),
    .count(level), .head, .head_tag_raw,
    .we, .waddr, .wdata, .wtag,
    .scan_idx, .scan_data, .scan_tag
  );

  tbf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk, .we, .waddr, .wdata, .wtag,
    .head_addr(head), .head_data(rd_data), .head_tag_raw,
    .scan_addr(scan_idx), .scan_data, .scan_tag,
    .tags_all
  );

  tbf_scan #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_scan (
    .tags_all, .head, .count(level), .query(query_tag), .hit(has_tag)
  );

  assign op_status = status_q;
  assign head_tag  = (level == '0) ? NO_TAG : head_tag_raw;
endmodule

// File: tb/test_tagged_byte_fifo.sv
module test_tagged_byte_fifo;
  localparam int DEPTH = 256;
  localparam int MAXB  = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_req_valid = 0, wr_valid = 0, pop_req_valid = 0, rd_ready = 0, purge_start = 0;
  logic [7:0] push_len = 0, push_tag = 0, wr_data = 0, pop_len = 0, pop_tag = 0;
  logic [7:0] purge_tag = 0, query_tag = 0;
  logic push_req_ready, wr_ready, pop_req_ready, rd_valid, purge_busy, op_done, has_tag;
  logic [7:0] rd_data, head_tag;
  logic [1:0] op_status;
  logic [8:0] level;

  int checks = 0, errors = 0, cycles = 0;
  byte unsigned mdata[$];
  byte unsigned mtag[$];

  always #5 clk = ~clk;

  tagged_byte_fifo i_tagged_byte_fifo (
    .clk, .rst, .push_req_valid, .push_req_ready, .push_len, .push_tag,
    .wr_valid, .wr_ready, .wr_data, .pop_req_valid, .pop_req_ready, .pop_len, .pop_tag,
    .rd_valid, .rd_ready, .rd_data, .purge_start, .purge_tag, .purge_busy,
    .op_done, .op_status, .level, .head_tag, .query_tag, .has_tag
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog R11: actual %0d cycles expected below 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "level", int'(level), mdata.size());
    chk(req, "head_tag", int'(head_tag), mdata.size() == 0 ? 255 : int'(mtag[0]));
  endtask

  task automatic push_op(input int tag, input int len, input int seed, input string req);
    int exp_st;
    exp_st = (len == 0 || len > MAXB) ? 2 : ((DEPTH - mdata.size()) < len ? 1 : 0);
    push_req_valid = 1; push_len = 8'(len); push_tag = 8'(tag);
    while (!push_req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    push_req_valid = 0;
    if (exp_st == 0) begin
      for (int i = 0; i < len; i++) begin
        wr_valid = 1; wr_data = 8'(seed + i);
        mdata.push_back(8'(seed + i)); mtag.push_back(8'(tag));
        @(posedge clk); @(negedge clk);
      end
      wr_valid = 0;
    end
    chk(req, "push done", int'(op_done), 1);
    chk(req, "push status", int'(op_status), exp_st);
    @(negedge clk);
    chk("R11", "done single pulse", int'(op_done), 0);
  endtask

  task automatic pop_op(input int tag, input int len, input string req);
    int exp_st;
    logic [7:0] held;
    if (len == 0 || len > MAXB) exp_st = 2;
    else if (mdata.size() < len) exp_st = 1;
    else if (int'(mtag[0]) != tag) exp_st = 2;
    else exp_st = 0;
    pop_req_valid = 1; pop_len = 8'(len); pop_tag = 8'(tag);
    while (!pop_req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    pop_req_valid = 0;
    if (exp_st == 0) begin
      held = rd_data;
      rd_ready = 0;
      @(posedge clk); @(negedge clk);
      chk("R6", "rd_valid held", int'(rd_valid), 1);
      chk("R6", "rd_data held", int'(rd_data), int'(held));
      for (int i = 0; i < len; i++) begin
        chk(req, "pop byte", int'(rd_data), int'(mdata[0]));
        void'(mdata.pop_front()); void'(mtag.pop_front());
        rd_ready = 1;
        @(posedge clk); @(negedge clk);
      end
      rd_ready = 0;
    end
    chk(req, "pop done", int'(op_done), 1);
    chk(req, "pop status", int'(op_status), exp_st);
    @(negedge clk);
  endtask

  task automatic purge_op(input int tag);
    int n = 0;
    int exp_n = mdata.size() + 1;
    purge_start = 1; purge_tag = 8'(tag);
    @(posedge clk); @(negedge clk);
    purge_start = 0;
    while (purge_busy && n < 5000) begin
      if (n == 1) begin
        chk("R9", "push blocked in purge", int'(push_req_ready), 0);
        chk("R9", "pop blocked in purge", int'(pop_req_ready), 0);
      end
      n++;
      @(posedge clk); @(negedge clk);
    end
    chk("R9", "purge busy cycles", n, exp_n);
    chk("R9", "purge done", int'(op_done), 1);
    for (int i = mdata.size() - 1; i >= 0; i--)
      if (int'(mtag[i]) == tag) begin mdata.delete(i); mtag.delete(i); end
    check_state("R9");
    query_tag = 8'(tag); #1;
    chk("R9", "purged tag absent", int'(has_tag), 0);
  endtask

  task automatic t_reset;
    check_state("R1");
    chk("R1", "has_tag", int'(has_tag), 0);
    chk("R1", "busy", int'(purge_busy), 0);
    chk("R1", "push ready", int'(push_req_ready), 1);
    chk("R7", "empty head tag", int'(head_tag), 255);
  endtask

  task automatic t_basic;
    push_op(1, 4, 8'h10, "R2");
    check_state("R7");
    query_tag = 1; #1; chk("R8", "tag1 present", int'(has_tag), 1);
    query_tag = 2; #1; chk("R8", "tag2 absent", int'(has_tag), 0);
    push_op(2, 3, 8'h40, "R2");
    query_tag = 2; #1; chk("R8", "tag2 present", int'(has_tag), 1);
    pop_op(2, 2, "R5");
    check_state("R5");
    pop_op(1, 4, "R5");
    check_state("R6");
    pop_op(2, 5, "R4");
    check_state("R4");
  endtask

  task automatic t_lengths;
    push_op(7, 0, 0, "R10");
    push_op(7, 129, 0, "R10");
    pop_op(2, 0, "R10");
    check_state("R10");
  endtask

  task automatic t_full_and_purge;
    push_op(3, 128, 8'h80, "R2");
    push_op(4, 124, 8'h20, "R2");
    push_op(5, 2, 8'hE0, "R3");
    check_state("R3");
    push_op(5, 1, 8'hF0, "R2");
    check_state("R2");
    purge_op(3);
    pop_op(2, 3, "R3");
    pop_op(4, 124, "R6");
    pop_op(5, 1, "R6");
    check_state("R6");
  endtask

  task automatic t_priority;
    pop_req_valid = 1; push_req_valid = 1; #1;
    chk("R10", "pop ready with both", int'(pop_req_ready), 1);
    chk("R10", "push ready with both", int'(push_req_ready), 0);
    purge_start = 1; #1;
    chk("R10", "pop ready under purge", int'(pop_req_ready), 0);
    pop_req_valid = 0; push_req_valid = 0; purge_start = 0; #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_priority();
    t_full_and_purge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule